// File: doc/BRIEF.md
# Shared Descriptor Ring Bridge

This block joins two streaming engines through one ring of buffer descriptors. A receive engine takes bytes from an input link and fills fixed 16-byte buffers. A transmit engine drains closed buffers to an output link. Each descriptor has a single status bit, and that bit is the only link between the two engines. When the receive side is set to inverted polarity, the receiver's "buffer full" mark is also the transmitter's "ready to send" mark, so buffers pass from one engine to the other with no host action.

Each engine keeps its own pointer into the ring. A per-descriptor wrap bit sets the ring length. A start gate can hold the transmitter until a chosen buffer index has been closed by the receiver. Two sticky interrupt flags, each with its own enable, report buffer closes and receive stalls. The flags are cleared by a write-one-to-clear pulse.

Top module: `bd_ring_bridge`

## Requirements
- R1: After reset every status bit is 0, both pointers and byte counts are 0, `out_valid` is 0 and `irq_flags` is 0. `in_ready` reflects whether the receiver owns descriptor 0.
- R2: With `cfg_inv_pol`=1, the receiver accepts bytes only into a descriptor whose status bit is 0. On the 16th byte it sets that bit to 1, and the transmitter may present the buffer from the next cycle on.
- R3: With `cfg_inv_pol`=0, the receiver owns only descriptors whose bit is 1, and on close it clears the bit to 0. Right after reset it therefore holds `in_ready` low.
- R4: The transmitter presents the 16 bytes of its current descriptor in order, only while that descriptor's bit is 1. It holds `out_data` steady while `out_ready` is low, and it clears the bit to 0 after the last byte.
- R5: A pointer moves to index 0 after a descriptor whose `cfg_wrap` bit is set, or after the last index. Otherwise it moves to the next index.
- R6: When the receiver's current descriptor is not owned, `in_ready` is 0 and no byte is stored. An offered byte (`in_valid`=1) sets the error flag `irq_flags[1]`, and buffered data stays intact.
- R7: With `cfg_gate_en`=1, `out_valid` stays 0 until the receiver closes descriptor `cfg_gate_idx`. After that the transmitter runs on its own, starting at index 0.
- R8: Every buffer close sets the sticky flag `irq_flags[0]`. A 1 in `irq_clr` clears the matching flag, unless the same flag is set again in that cycle.
- R9: `irq` is high exactly when some flag is set and its bit in `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_inv_pol | input | 1 | Receiver empty-bit polarity: 1 = inverted (fill when bit is 0) |
| cfg_wrap | input | NUM_BD | Per-descriptor wrap bits |
| cfg_gate_en | input | 1 | Hold the transmitter until the gate buffer closes |
| cfg_gate_idx | input | $clog2(NUM_BD) | Index of the buffer that opens the gate |
| irq_en | input | 2 | Interrupt enables: bit 0 close, bit 1 error |
| irq_clr | input | 2 | Write-one-to-clear pulses for the flags |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Receiver can accept a byte |
| in_data | input | DW | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output link accepts the byte |
| out_data | output | DW | Output byte |
| irq_flags | output | 2 | Sticky flags: bit 0 close, bit 1 error |
| irq | output | 1 | Enabled interrupt request |

## Verification
The assertions assume that the configuration inputs hold still between resets. The hold-steady and pointer-separation checks also assume inverted polarity, because in normal polarity both engines may legally work on the same descriptor. The stimulus therefore sets every configuration value while reset is asserted and never changes it during a scenario. It also drives `in_valid` against a blocked receiver only to provoke the error flag.

// File: rtl/bd_ring_bridge.sv
module bd_ring_bridge #(
  parameter int NUM_BD  = 8,
  parameter int BUF_LEN = 16,
  parameter int DW      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_inv_pol,
  input  logic [NUM_BD-1:0]         cfg_wrap,
  input  logic                      cfg_gate_en,
  input  logic [$clog2(NUM_BD)-1:0] cfg_gate_idx,
  input  logic [1:0]                irq_en,
  input  logic [1:0]                irq_clr,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DW-1:0]             in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DW-1:0]             out_data,
  output logic [1:0]                irq_flags,
  output logic                      irq
);
  localparam int IW = $clog2(NUM_BD);
  localparam int CW = $clog2(BUF_LEN);
  localparam int DEPTH = NUM_BD * BUF_LEN;

  logic [NUM_BD-1:0] st;
  logic [DW-1:0]     mem [DEPTH];
  logic [IW-1:0]     rp, tp;
  logic [CW-1:0]     rc, tc;
  logic              armed;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p, input logic [NUM_BD-1:0] w);
    return (w[p] || p == IW'(NUM_BD-1)) ? '0 : p + 1'b1;
  endfunction

  wire rx_own   = st[rp] != cfg_inv_pol;
  wire tx_go    = !cfg_gate_en || armed;
  wire wr       = in_valid && in_ready;
  wire rd       = out_valid && out_ready;
  wire rx_close = wr && rc == CW'(BUF_LEN-1);
  wire tx_done  = rd && tc == CW'(BUF_LEN-1);

  assign in_ready  = rx_own;
  assign out_valid = tx_go && st[tp];
  assign out_data  = mem[{tp, tc}];
  assign irq       = |(irq_flags & irq_en);

  always_ff @(posedge clk)
    if (wr) mem[{rp, rc}] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0; rp <= '0; tp <= '0; rc <= '0; tc <= '0;
      armed <= 1'b0; irq_flags <= '0;
    end else begin
      if (wr) rc <= rc + 1'b1;
      if (rd) tc <= tc + 1'b1;
      if (rx_close) begin
        st[rp] <= cfg_inv_pol;
        rp <= nxt(rp, cfg_wrap);
        if (rp == cfg_gate_idx) armed <= 1'b1;
      end
      if (tx_done) begin
        st[tp] <= 1'b0;
        tp <= nxt(tp, cfg_wrap);
      end
      irq_flags <= (irq_flags & ~irq_clr) | {in_valid && !in_ready, rx_close};
    end
  end

  a_r6_stall_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> irq_flags[1]);
  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_inv_pol && out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r2_apart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_inv_pol && in_ready && out_valid |-> rp != tp);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags[0] && !irq_clr[0] |=> irq_flags[0]);
  a_r7_gate_stays: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: tb/tb_bd_ring_bridge.sv
`timescale 1ns/1ps
module tb_bd_ring_bridge;
  logic clk = 0, rst_n = 0;
  logic cfg_inv_pol = 1, cfg_gate_en = 0;
  logic [7:0] cfg_wrap = 0;
  logic [2:0] cfg_gate_idx = 0;
  logic [1:0] irq_en = 0, irq_clr = 0, irq_flags;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, irq;
  logic [7:0] in_data = 0, out_data;
  int vecs = 0, errs = 0;

  always #2 clk = ~clk;

  bd_ring_bridge dut (.clk, .rst_n, .cfg_inv_pol, .cfg_wrap, .cfg_gate_en, .cfg_gate_idx,
    .irq_en, .irq_clr, .in_valid, .in_ready, .in_data, .out_valid, .out_ready, .out_data,
    .irq_flags, .irq);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic do_reset(input logic inv, input logic [7:0] wrap, input logic gen, input logic [2:0] gidx);
    @(negedge clk); rst_n = 0; cfg_inv_pol = inv; cfg_wrap = wrap; cfg_gate_en = gen;
    cfg_gate_idx = gidx; irq_en = 0; irq_clr = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] base, input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_valid = 1; in_data = base + 8'(i);
      chk(in_ready === 1'b1, req, in_ready, 1);
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic pull(input logic [7:0] base, input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); out_ready = 1;
      chk(out_valid === 1'b1 && out_data === base + 8'(i), req, out_data, base + 8'(i));
    end
    @(negedge clk); out_ready = 0;
  endtask

  task automatic t_reset;
    do_reset(1, 8'h00, 0, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(irq_flags === 2'b00, "R1 flags", irq_flags, 0);
  endtask

  task automatic t_basic;
    do_reset(1, 8'h00, 0, 0);
    push(8'h10, "R2 fill");
    chk(irq_flags[0] === 1'b1, "R8 close flag", irq_flags, 1);
    chk(irq === 1'b0, "R9 masked", irq, 0);
    irq_en = 2'b01; #0.1;
    chk(irq === 1'b1, "R9 enabled", irq, 1);
    chk(out_valid === 1'b1 && out_data === 8'h10, "R2 handover", out_data, 8'h10);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_data === 8'h10, "R4 hold", out_data, 8'h10);
    pull(8'h10, "R4 send");
    chk(out_valid === 1'b0, "R4 cleared idle", out_valid, 0);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 0;
    chk(irq_flags[0] === 1'b0 && irq === 1'b0, "R8 w1c", irq_flags, 0);
  endtask

  task automatic t_gate;
    do_reset(1, 8'h00, 1, 3'd2);
    push(8'h20, "R7 fill0"); push(8'h40, "R7 fill1");
    chk(out_valid === 1'b0, "R7 gated", out_valid, 0);
    push(8'h60, "R7 fill2");
    chk(out_valid === 1'b1, "R7 opened", out_valid, 1);
    pull(8'h20, "R7 order0"); pull(8'h40, "R7 order1"); pull(8'h60, "R7 order2");
  endtask

  task automatic t_overrun;
    do_reset(1, 8'h02, 0, 0);
    push(8'hA0, "R6 fillA"); push(8'hB0, "R6 fillB");
    chk(in_ready === 1'b0, "R6 blocked", in_ready, 0);
    @(negedge clk); in_valid = 1; in_data = 8'hEE;
    @(negedge clk); in_valid = 0;
    chk(irq_flags[1] === 1'b1, "R6 err flag", irq_flags, 2);
    pull(8'hA0, "R6 intactA");
    chk(in_ready === 1'b1, "R5 rx wrap", in_ready, 1);
    push(8'hC0, "R5 refill");
    pull(8'hB0, "R6 intactB");
    pull(8'hC0, "R5 tx wrap");
  endtask

  task automatic t_normal;
    do_reset(0, 8'h00, 0, 0);
    chk(in_ready === 1'b0, "R3 not owned", in_ready, 0);
    @(negedge clk); in_valid = 1; in_data = 8'h55;
    @(negedge clk); in_valid = 0;
    chk(irq_flags === 2'b10, "R3 err only", irq_flags, 2);
    chk(out_valid === 1'b0, "R3 no output", out_valid, 0);
  endtask

  initial begin
    t_reset(); t_basic(); t_gate(); t_overrun(); t_normal();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #400000;
    errs++; $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule